// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock

This block makes the data-hazard decisions for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the source registers of the instruction in execute. It compares them with the destinations of the two older instructions that now sit in the memory and writeback stages. From that it picks, for each ALU operand on its own, whether the value comes from the register file, from the result held at the end of the memory stage, or from the result held at the end of writeback.

It also compares the source registers of the instruction in decode with the destination of a load that is in execute. The load's data does not exist until the end of the memory stage, so a dependent instruction directly behind it cannot be served by forwarding. In that case the block raises a stall that holds the PC and the fetch/decode register. In the same cycle it raises a bubble, which makes the decode/execute register take a do-nothing entry equal to add x0, x0, x0. One cycle later the load is in writeback, the dependent instruction is in execute, and the normal forwarding path supplies the loaded value. The register file writes before it reads within a cycle, so a producer in writeback never needs a check against decode.

The block only decides. The register file, the operand multiplexers and the ALU sit around it. All decisions are combinational and are valid in the same cycle as the stage contents they describe.

Top module: `hzu_top`

## Requirements
- R1: When the instruction in the memory stage has write-enable high, a nonzero destination, and a destination equal to an execute-stage source, that operand's select is 2'b10 (take the memory-stage result).
- R2: When only the instruction in writeback has write-enable high, a nonzero destination, and a destination matching an execute-stage source, that operand's select is 2'b01 (take the writeback result).
- R3: When both the memory-stage and the writeback producers match the same source, the memory-stage (younger) result wins and the select is 2'b10.
- R4: A producer whose destination is x0 or whose write-enable is low causes no forwarding and no stall. With no valid match, the select is 2'b00 (register file).
- R5: Operand A is selected from execute source 1 and operand B from execute source 2, each on its own. One instruction can take A from one stage and B from another.
- R6: When the instruction in execute is a load with write-enable high and a nonzero destination that equals either decode source, stall and bubble are both 1 in that same cycle. A dependent instruction right after a load is therefore delayed by exactly one cycle and then forwarded from writeback.
- R7: No stall is raised when the instruction in execute is not a load, even if it feeds decode, or when a load's destination matches neither decode source.
- R8: Destinations in the memory and writeback stages never cause a stall, whatever their value; stall and bubble are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only to sample the embedded checks |
| rst_n | input | 1 | Active-low reset, disables the embedded checks |
| id_rs1 | input | AW | Source register 1 of the instruction in decode |
| id_rs2 | input | AW | Source register 2 of the instruction in decode |
| ex_rs1 | input | AW | Source register 1 of the instruction in execute |
| ex_rs2 | input | AW | Source register 2 of the instruction in execute |
| ex_rd | input | AW | Destination of the instruction in execute |
| ex_we | input | 1 | Register write-enable of the instruction in execute |
| ex_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | AW | Destination of the instruction in the memory stage |
| mem_we | input | 1 | Register write-enable of the instruction in the memory stage |
| wb_rd | input | AW | Destination of the instruction in writeback |
| wb_we | input | 1 | Register write-enable of the instruction in writeback |
| fwd_a | output | 2 | Operand A source: 00 register file, 10 memory stage, 01 writeback |
| fwd_b | output | 2 | Operand B source, same encoding |
| stall | output | 1 | Hold the PC and the fetch/decode register |
| bubble | output | 1 | Load a do-nothing entry into the decode/execute register |

## Verification
Every result is combinational, so the selects and the stall are due in the same cycle that the stage contents are presented. The bench applies the stage contents on the falling edge and compares them one time unit later, before the next rising edge moves the modelled pipeline. The effect of a stall shows up one cycle later: the held decode instruction reaches execute after the bubble, and its forwarding selects are checked there. The total stall count is compared at the end.

// File: rtl/hzu_pkg.sv
package hzu_pkg;

    // Operand source encoding shared by the selector and its users
    typedef enum logic [1:0] {
        SEL_REGFILE = 2'b00,
        SEL_WB      = 2'b01,
        SEL_MEM     = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic [1:0] fwd_a;
        logic [1:0] fwd_b;
        logic       stall;
        logic       bubble;
    } hz_dec_t;

endpackage

// File: rtl/hzu_match.sv
module hzu_match #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic          wen,
    output logic          hit
);
    // A producer counts only if it writes a register other than the zero register
    always_comb begin
        hit = wen && (dst != '0) && (dst == src);
    end
endmodule

// File: rtl/hzu_opsel.sv
module hzu_opsel
    import hzu_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_we,
    output logic [1:0]    sel
);
    logic hit_mem;
    logic hit_wb;

    hzu_match #(.AW(AW)) u_mem (.src(src), .dst(mem_rd), .wen(mem_we), .hit(hit_mem));
    hzu_match #(.AW(AW)) u_wb  (.src(src), .dst(wb_rd),  .wen(wb_we),  .hit(hit_wb));

    // The younger producer holds the newer value and therefore has priority
    always_comb begin
        if (hit_mem)
            sel = SEL_MEM;
        else if (hit_wb)
            sel = SEL_WB;
        else
            sel = SEL_REGFILE;
    end
endmodule

// File: rtl/hzu_loaduse.sv
module hzu_loaduse #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic          ex_load,
    output logic          hold
);
    logic hit1;
    logic hit2;

    hzu_match #(.AW(AW)) u_s1 (.src(id_rs1), .dst(ex_rd), .wen(ex_we), .hit(hit1));
    hzu_match #(.AW(AW)) u_s2 (.src(id_rs2), .dst(ex_rd), .wen(ex_we), .hit(hit2));

    // Only a load is too late for forwarding into the next instruction
    always_comb begin
        hold = ex_load && (hit1 || hit2);
    end
endmodule

// File: rtl/hzu_top.sv
module hzu_top
    import hzu_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic [AW-1:0] ex_rs1,
    input  logic [AW-1:0] ex_rs2,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic          ex_load,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_we,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          stall,
    output logic          bubble
);
    localparam int NUM_OPS = 2;

    logic [AW-1:0] ex_src [NUM_OPS];
    logic [1:0]    op_sel [NUM_OPS];
    logic          hold;
    hz_dec_t       dec_d;

    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        hzu_opsel #(.AW(AW)) u_sel (
            .src    (ex_src[g]),
            .mem_rd (mem_rd),
            .mem_we (mem_we),
            .wb_rd  (wb_rd),
            .wb_we  (wb_we),
            .sel    (op_sel[g])
        );
    end

    hzu_loaduse #(.AW(AW)) u_lu (
        .id_rs1  (id_rs1),
        .id_rs2  (id_rs2),
        .ex_rd   (ex_rd),
        .ex_we   (ex_we),
        .ex_load (ex_load),
        .hold    (hold)
    );

    // Decisions are needed in the cycle the stage contents are present
    always_comb begin
        dec_d        = '0;
        dec_d.fwd_a  = op_sel[0];
        dec_d.fwd_b  = op_sel[1];
        dec_d.stall  = hold;
        dec_d.bubble = hold;
    end

    assign fwd_a  = dec_d.fwd_a;
    assign fwd_b  = dec_d.fwd_b;
    assign stall  = dec_d.stall;
    assign bubble = dec_d.bubble;

    // R1/R3: a valid memory-stage producer always wins operand A
    a_r1_mem_wins_a: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_rd != '0 && mem_rd == ex_rs1) |-> fwd_a == SEL_MEM);

    // R2: writeback only when the memory stage does not match
    a_r2_wb_only_b: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_we && wb_rd != '0 && wb_rd == ex_rs2 &&
         !(mem_we && mem_rd != '0 && mem_rd == ex_rs2)) |-> fwd_b == SEL_WB);

    // R4: never forward into a zero-register source
    a_r4_no_x0_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a != SEL_REGFILE) |-> (ex_rs1 != '0));

    // R5: operand B follows source 2 from the memory stage
    a_r5_mem_wins_b: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_rd != '0 && mem_rd == ex_rs2) |-> fwd_b == SEL_MEM);

    // R6: a load feeding decode interlocks
    a_r6_load_use: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_load && ex_we && ex_rd != '0 && (ex_rd == id_rs1 || ex_rd == id_rs2))
        |-> (stall && bubble));

    // R7: non-loads never interlock
    a_r7_nonload_free: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_load |-> !stall);

    // R8: a stall always traces back to the execute-stage destination
    a_r8_stall_source: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (ex_rd != '0 && (ex_rd == id_rs1 || ex_rd == id_rs2) && bubble));
endmodule

// File: tb/sim_hzu_top.sv
module sim_hzu_top;

    localparam int AW    = 5;
    localparam int NPROG = 30;

    typedef struct {
        int          tag;
        logic [4:0]  rd;
        logic [4:0]  rs1;
        logic [4:0]  rs2;
        logic        we;
        logic        ld;
    } ins_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0;
    logic [AW-1:0] ex_rd = '0, mem_rd = '0, wb_rd = '0;
    logic          ex_we = 1'b0, ex_load = 1'b0, mem_we = 1'b0, wb_we = 1'b0;
    logic [1:0]    fwd_a, fwd_b;
    logic          stall, bubble;

    int checks = 0;
    int failures = 0;
    int dut_stalls = 0;
    int ref_stalls = 0;
    bit done = 1'b0;

    ins_t prog [NPROG];
    int   obs_a [NPROG];
    int   obs_b [NPROG];
    ins_t s_ifid, s_idex, s_exmem, s_memwb;
    int   pc;

    always #2.5 clk = ~clk;

    hzu_top #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load),
        .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .bubble(bubble)
    );

    function automatic ins_t nop();
        ins_t n;
        n.tag = -1; n.rd = 0; n.rs1 = 0; n.rs2 = 0; n.we = 1'b1; n.ld = 1'b0;
        return n;
    endfunction

    task automatic put(int i, int rd, int rs1, int rs2, bit we, bit ld);
        prog[i].tag = i; prog[i].rd = rd[4:0]; prog[i].rs1 = rs1[4:0];
        prog[i].rs2 = rs2[4:0]; prog[i].we = we; prog[i].ld = ld;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference: select from the required priority of producers
    function automatic int ref_sel(logic [4:0] src);
        if (s_exmem.we && s_exmem.rd != 0 && s_exmem.rd == src) return 2;
        if (s_memwb.we && s_memwb.rd != 0 && s_memwb.rd == src) return 1;
        return 0;
    endfunction

    function automatic string sel_req(int e);
        if (e == 2) return "R1";
        if (e == 1) return "R2";
        return "R4";
    endfunction

    initial begin : watchdog
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < NPROG; i++) begin
            put(i, 0, 0, 0, 1, 0);
            prog[i].tag = -1;
            obs_a[i] = -1; obs_b[i] = -1;
        end
        put(0, 8, 1, 2, 1, 0);    // producer for the four consumers
        put(1, 20, 8, 3, 1, 0);
        put(2, 21, 8, 4, 1, 0);
        put(3, 22, 8, 5, 1, 0);
        put(4, 23, 6, 8, 1, 0);
        put(8, 5, 6, 0, 1, 1);    // load then dependent
        put(9, 7, 5, 11, 1, 0);
        put(13, 12, 6, 0, 1, 1);  // load, independent, then user
        put(14, 13, 1, 2, 1, 0);
        put(15, 14, 12, 12, 1, 0);
        put(16, 0, 6, 0, 1, 1);   // load into x0
        put(17, 15, 0, 0, 1, 0);
        put(18, 16, 1, 2, 1, 0);  // same destination twice
        put(19, 16, 3, 4, 1, 0);
        put(20, 17, 16, 16, 1, 0);
        put(21, 24, 1, 2, 1, 0);
        put(22, 25, 1, 2, 1, 0);
        put(23, 26, 25, 24, 1, 0);
        put(24, 27, 1, 2, 0, 0);  // no register write
        put(25, 28, 27, 27, 1, 0);
        put(26, 29, 1, 2, 1, 0);  // ALU producer directly followed by user
        put(27, 30, 29, 29, 1, 0);
        put(28, 31, 6, 0, 1, 1);  // load used through source 2
        put(29, 0, 1, 31, 0, 0);

        s_ifid = nop(); s_idex = nop(); s_exmem = nop(); s_memwb = nop();
        pc = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R4", "reset fwd_a", fwd_a, 0);
        chk("R4", "reset fwd_b", fwd_b, 0);
        chk("R8", "reset stall", stall, 0);
        chk("R8", "reset bubble", bubble, 0);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < NPROG + 12; cyc++) begin
            @(negedge clk);
            id_rs1 = s_ifid.rs1;  id_rs2 = s_ifid.rs2;
            ex_rs1 = s_idex.rs1;  ex_rs2 = s_idex.rs2;
            ex_rd = s_idex.rd;    ex_we = s_idex.we;   ex_load = s_idex.ld;
            mem_rd = s_exmem.rd;  mem_we = s_exmem.we;
            wb_rd = s_memwb.rd;   wb_we = s_memwb.we;
            #1;
            begin
                int ea, eb;
                bit es;
                ea = ref_sel(s_idex.rs1);
                eb = ref_sel(s_idex.rs2);
                es = s_idex.ld && s_idex.we && s_idex.rd != 0 &&
                     (s_idex.rd == s_ifid.rs1 || s_idex.rd == s_ifid.rs2);
                chk(sel_req(ea), "cycle fwd_a", fwd_a, ea);
                chk(sel_req(eb), "cycle fwd_b", fwd_b, eb);
                chk(es ? "R6" : "R7", "cycle stall", stall, es);
                chk("R8", "cycle bubble", bubble, stall);
                if (s_idex.tag >= 0) begin
                    obs_a[s_idex.tag] = fwd_a;
                    obs_b[s_idex.tag] = fwd_b;
                end
                if (stall) dut_stalls++;
                // advance the modelled pipeline by one edge
                s_memwb = s_exmem;
                s_exmem = s_idex;
                if (es) begin
                    ref_stalls++;
                    s_idex = nop();
                end else begin
                    s_idex = s_ifid;
                    s_ifid = (pc < NPROG) ? prog[pc] : nop();
                    pc++;
                end
            end
        end

        // Hand-derived expectations per instruction reaching execute
        chk("R1", "sub after add a", obs_a[1], 2);
        chk("R2", "and two behind a", obs_a[2], 1);
        chk("R4", "or three behind a", obs_a[3], 0);
        chk("R4", "xor four behind b", obs_b[4], 0);
        chk("R6", "load user a after stall", obs_a[9], 1);
        chk("R7", "load user two behind a", obs_a[15], 1);
        chk("R7", "load user two behind b", obs_b[15], 1);
        chk("R4", "x0 load user a", obs_a[17], 0);
        chk("R3", "priority a", obs_a[20], 2);
        chk("R3", "priority b", obs_b[20], 2);
        chk("R5", "split a", obs_a[23], 2);
        chk("R5", "split b", obs_b[23], 1);
        chk("R4", "we low a", obs_a[25], 0);
        chk("R4", "we low b", obs_b[25], 0);
        chk("R7", "alu user a", obs_a[27], 2);
        chk("R6", "load via rs2 b", obs_b[29], 1);
        chk("R6", "stall count", dut_stalls, 2);
        chk("R6", "model stall count", ref_stalls, 2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule